// File: doc/BRIEF.md
# Mixed-Page-Size Translation Buffer

This block is a fully associative translation lookaside buffer. Each of its entries maps one virtual page to one physical page. Pages of four sizes (4 KB, 8 KB, 1 MB and 16 MB) can sit side by side in the same array, and each entry compares only the virtual address bits above its own page offset. A lookup presents a virtual address and the current 8-bit address space identifier. The block answers in the same cycle with a hit flag, the translated physical address and the entry's attribute bits. An entry marked shared matches under any identifier.

Software manages the array through a 64 KB register window. The window's base is set through a dedicated base port and has a valid bit. Software stages an entry in the tag and data registers and then commits it with a command in the operation register. The commit goes to a round-robin slot. The same register path also reads entries back and invalidates the whole array. When a lookup misses, the block raises a sticky flag and latches the faulting virtual address, so the access can be replayed once the mapping has been installed. If several entries match one address, the lowest-numbered entry wins.

Top module: `xlat_tlb`

## Requirements
- R1: After reset, every window register (control 0x00, operation 0x04, status 0x08, fault address 0x10, tag 0x14, data 0x18) reads zero, the replacement pointer is 0, and no lookup hits.
- R2: Writing 1 to bit 0 of the operation register commits the tag and data registers into the entry the replacement pointer selects. The pointer then advances by one, and it wraps from NUM_ENT-1 to 0. Reads of the operation register return the pointer in its low bits.
- R3: A 4 KB entry (size code 00) matches on virtual address bits 31:12. The physical address is the entry's page number in bits 31:12, with bits 11:0 taken from the virtual address.
- R4: Size codes 01, 10 and 11 (8 KB, 1 MB, 16 MB) compare only the virtual address bits at or above bit 13, 20 and 24 respectively. The bits below that boundary pass straight from the virtual address into the physical address.
- R5: An entry matches only if its identifier equals the lookup identifier. The one exception is when its shared bit (tag bit 3) is set. Tag layout: bits 31:12 page number, 11:4 identifier, 3 shared, 2:1 size code, 0 valid. Data layout: bits 31:12 physical page, bits 3:0 attributes.
- R6: When more than one entry matches, the result comes from the lowest-index matching entry.
- R7: The hit flag, physical address and attributes are valid combinationally, in the same cycle as the lookup request.
- R8: A lookup miss while translation is enabled sets status bit 0 and copies the virtual address into the fault address register. Later misses leave both unchanged. Writing 1 to status bit 0 clears the flag.
- R9: The window answers only while base bit 0 is set, and only to addresses whose bits 31:16 equal the base's bits 31:16 and whose bits 1:0 are zero. Any other access writes nothing and reads zero.
- R10: Writing 1 to bit 2 of the operation register loads the tag and data registers from the entry indexed by the fault address register's low bits.
- R11: Writing 1 to bit 1 of the operation register clears the valid bit of every entry.
- R12: While control bit 0 is clear, lookups never hit and no miss is recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| base_we | input | 1 | Load the window base register |
| base_in | input | 32 | New base: bits 31:16 address, bit 0 valid |
| rg_wr | input | 1 | Register write strobe |
| rg_rd | input | 1 | Register read strobe |
| rg_addr | input | 32 | Register access address |
| rg_wdata | input | 32 | Register write data |
| rg_rdata | output | 32 | Register read data, combinational |
| lk_valid | input | 1 | Lookup request |
| lk_va | input | 32 | Lookup virtual address |
| lk_asid | input | 8 | Current address space identifier |
| lk_hit | output | 1 | Lookup hit |
| lk_pa | output | 32 | Translated physical address |
| lk_attr | output | 4 | Attributes of the hitting entry |

## Verification
The lookup outputs and register read data are combinational, so the bench drives each request just after a falling edge and samples one time unit later, in the same cycle. Register writes, commits, invalidations and readbacks take effect at the following rising edge. The miss flag and fault address are updated at the rising edge that ends the lookup cycle. Because of this, every such effect is checked by a read in a later cycle, after that edge has passed and before the next stimulus is applied.

// File: rtl/xlat_pkg.sv
`timescale 1ns/1ps
package xlat_pkg;

   localparam int ADDR_W = 32;
   localparam int PAGE_W = 20;
   localparam int ID_W   = 8;
   localparam int ATTR_W = 4;

   typedef enum logic [1:0] {
      PG_4K  = 2'b00,
      PG_8K  = 2'b01,
      PG_1M  = 2'b10,
      PG_16M = 2'b11
   } pg_size_e;

   typedef struct packed {
      logic              valid;
      logic              shared;
      pg_size_e          size;
      logic [ID_W-1:0]   asid;
      logic [PAGE_W-1:0] vpn;
      logic [PAGE_W-1:0] ppn;
      logic [ATTR_W-1:0] attr;
   } tlb_ent_t;

   // offset bits of a page of the given size
   function automatic logic [ADDR_W-1:0] offset_mask(pg_size_e s);
      case (s)
         PG_4K:   return 32'h0000_0FFF;
         PG_8K:   return 32'h0000_1FFF;
         PG_1M:   return 32'h000F_FFFF;
         default: return 32'h00FF_FFFF;
      endcase
   endfunction

   function automatic tlb_ent_t ent_unpack(logic [31:0] t, logic [31:0] d);
      tlb_ent_t e;
      e.vpn    = t[31:12];
      e.asid   = t[11:4];
      e.shared = t[3];
      e.size   = pg_size_e'(t[2:1]);
      e.valid  = t[0];
      e.ppn    = d[31:12];
      e.attr   = d[ATTR_W-1:0];
      return e;
   endfunction

   function automatic logic [31:0] tag_pack(tlb_ent_t e);
      return {e.vpn, e.asid, e.shared, e.size, e.valid};
   endfunction

   function automatic logic [31:0] data_pack(tlb_ent_t e);
      return {e.ppn, 8'h00, e.attr};
   endfunction

endpackage

// File: rtl/xlat_match.sv
`timescale 1ns/1ps
module xlat_match
   import xlat_pkg::*;
#(
   parameter int NUM_ENT = 32
) (
   input  tlb_ent_t          ents [NUM_ENT],
   input  logic [ADDR_W-1:0] va,
   input  logic [ID_W-1:0]   asid,
   output logic [NUM_ENT-1:0] match
);

   for (genvar i = 0; i < NUM_ENT; i++) begin : g_ent
      logic [ADDR_W-1:0] off_m;
      logic [ADDR_W-1:0] vtag;
      logic              page_eq;
      logic              id_ok;

      assign off_m   = offset_mask(ents[i].size);
      assign vtag    = {ents[i].vpn, 12'h000};
      assign page_eq = ((va ^ vtag) & ~off_m) == '0;
      assign id_ok   = ents[i].shared || (ents[i].asid == asid);
      assign match[i] = ents[i].valid && page_eq && id_ok;
   end

endmodule

// File: rtl/xlat_prio.sv
`timescale 1ns/1ps
module xlat_prio #(
   parameter int N     = 32,
   parameter int IDX_W = $clog2(N)
) (
   input  logic [N-1:0]     req,
   output logic             any,
   output logic [IDX_W-1:0] idx
);

   // scan downward so the lowest set index is the last assigned
   always_comb begin
      any = 1'b0;
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) begin
            any = 1'b1;
            idx = IDX_W'(i);
         end
      end
   end

endmodule

// File: rtl/xlat_regs.sv
`timescale 1ns/1ps
module xlat_regs #(
   parameter int WIN_LOG2 = 16,
   parameter int IDX_W    = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             base_we,
   input  logic [31:0]      base_in,
   input  logic             rg_wr,
   input  logic             rg_rd,
   input  logic [31:0]      rg_addr,
   input  logic [31:0]      rg_wdata,
   output logic [31:0]      rg_rdata,
   input  logic [IDX_W-1:0] ptr,
   input  logic [31:0]      rb_tag,
   input  logic [31:0]      rb_data,
   input  logic             miss_evt,
   input  logic [31:0]      miss_va,
   output logic             ctrl_en,
   output logic             load_stb,
   output logic             inval_stb,
   output logic             win_sel,
   output logic             miss_flag,
   output logic [31:0]      fault_va,
   output logic [31:0]      tag_q,
   output logic [31:0]      data_q
);

   localparam logic [WIN_LOG2-1:0] OFF_CTRL = WIN_LOG2'('h00);
   localparam logic [WIN_LOG2-1:0] OFF_OPER = WIN_LOG2'('h04);
   localparam logic [WIN_LOG2-1:0] OFF_STAT = WIN_LOG2'('h08);
   localparam logic [WIN_LOG2-1:0] OFF_FADR = WIN_LOG2'('h10);
   localparam logic [WIN_LOG2-1:0] OFF_TAG  = WIN_LOG2'('h14);
   localparam logic [WIN_LOG2-1:0] OFF_DATA = WIN_LOG2'('h18);

   logic [31:WIN_LOG2]  base_hi;
   logic                base_ok;
   logic [31:0]         ctrl_q;
   logic [WIN_LOG2-1:0] off;
   logic                wr_ctrl, wr_oper, wr_stat, wr_fadr, wr_tag, wr_data;
   logic                rdbk_stb;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_hi <= '0;
         base_ok <= 1'b0;
      end else if (base_we) begin
         base_hi <= base_in[31:WIN_LOG2];
         base_ok <= base_in[0];
      end
   end

   assign off     = rg_addr[WIN_LOG2-1:0];
   assign win_sel = base_ok && (rg_addr[31:WIN_LOG2] == base_hi) && (rg_addr[1:0] == 2'b00);

   assign wr_ctrl = rg_wr && win_sel && (off == OFF_CTRL);
   assign wr_oper = rg_wr && win_sel && (off == OFF_OPER);
   assign wr_stat = rg_wr && win_sel && (off == OFF_STAT);
   assign wr_fadr = rg_wr && win_sel && (off == OFF_FADR);
   assign wr_tag  = rg_wr && win_sel && (off == OFF_TAG);
   assign wr_data = rg_wr && win_sel && (off == OFF_DATA);

   assign load_stb  = wr_oper && rg_wdata[0];
   assign inval_stb = wr_oper && rg_wdata[1];
   assign rdbk_stb  = wr_oper && rg_wdata[2];
   assign ctrl_en   = ctrl_q[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q    <= '0;
         miss_flag <= 1'b0;
         fault_va  <= '0;
         tag_q     <= '0;
         data_q    <= '0;
      end else begin
         if (wr_ctrl) ctrl_q <= rg_wdata;

         if (wr_stat && rg_wdata[0]) miss_flag <= 1'b0;
         else if (miss_evt)          miss_flag <= 1'b1;

         if (wr_fadr)                     fault_va <= rg_wdata;
         else if (miss_evt && !miss_flag) fault_va <= miss_va;

         if (rdbk_stb)    tag_q <= rb_tag;
         else if (wr_tag) tag_q <= rg_wdata;

         if (rdbk_stb)     data_q <= rb_data;
         else if (wr_data) data_q <= rg_wdata;
      end
   end

   always_comb begin
      rg_rdata = '0;
      if (rg_rd && win_sel) begin
         case (off)
            OFF_CTRL: rg_rdata = ctrl_q;
            OFF_OPER: rg_rdata = 32'(ptr);
            OFF_STAT: rg_rdata = {31'h0, miss_flag};
            OFF_FADR: rg_rdata = fault_va;
            OFF_TAG:  rg_rdata = tag_q;
            OFF_DATA: rg_rdata = data_q;
            default:  rg_rdata = '0;
         endcase
      end
   end

endmodule

// File: rtl/xlat_tlb.sv
`timescale 1ns/1ps
module xlat_tlb
   import xlat_pkg::*;
#(
   parameter int NUM_ENT  = 32,
   parameter int WIN_LOG2 = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              base_we,
   input  logic [31:0]       base_in,
   input  logic              rg_wr,
   input  logic              rg_rd,
   input  logic [31:0]       rg_addr,
   input  logic [31:0]       rg_wdata,
   output logic [31:0]       rg_rdata,
   input  logic              lk_valid,
   input  logic [31:0]       lk_va,
   input  logic [7:0]        lk_asid,
   output logic              lk_hit,
   output logic [31:0]       lk_pa,
   output logic [3:0]        lk_attr
);

   localparam int IDX_W = $clog2(NUM_ENT);

   if (NUM_ENT < 2 || (1 << IDX_W) != NUM_ENT) begin : g_bad_depth
      $error("xlat_tlb: NUM_ENT must be a power of two of at least 2");
   end
   if (WIN_LOG2 < 8 || WIN_LOG2 > 24) begin : g_bad_win
      $error("xlat_tlb: WIN_LOG2 out of range");
   end

   tlb_ent_t           ents [NUM_ENT];
   logic [IDX_W-1:0]   ptr_q;
   logic [NUM_ENT-1:0] match;
   logic               any_match;
   logic [IDX_W-1:0]   sel_idx;
   tlb_ent_t           sel_ent;
   tlb_ent_t           rb_ent;
   logic [31:0]        sel_mask;

   logic               ctrl_en, load_stb, inval_stb, win_sel, miss_flag, miss_evt;
   logic [31:0]        fault_va, tag_q, data_q;

   xlat_regs #(.WIN_LOG2(WIN_LOG2), .IDX_W(IDX_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .base_we   (base_we),
      .base_in   (base_in),
      .rg_wr     (rg_wr),
      .rg_rd     (rg_rd),
      .rg_addr   (rg_addr),
      .rg_wdata  (rg_wdata),
      .rg_rdata  (rg_rdata),
      .ptr       (ptr_q),
      .rb_tag    (tag_pack(rb_ent)),
      .rb_data   (data_pack(rb_ent)),
      .miss_evt  (miss_evt),
      .miss_va   (lk_va),
      .ctrl_en   (ctrl_en),
      .load_stb  (load_stb),
      .inval_stb (inval_stb),
      .win_sel   (win_sel),
      .miss_flag (miss_flag),
      .fault_va  (fault_va),
      .tag_q     (tag_q),
      .data_q    (data_q)
   );

   xlat_match #(.NUM_ENT(NUM_ENT)) u_match (
      .ents  (ents),
      .va    (lk_va),
      .asid  (lk_asid),
      .match (match)
   );

   xlat_prio #(.N(NUM_ENT), .IDX_W(IDX_W)) u_prio (
      .req (match),
      .any (any_match),
      .idx (sel_idx)
   );

   // entry storage and round-robin replacement
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q <= '0;
         for (int i = 0; i < NUM_ENT; i++) ents[i] <= '0;
      end else begin
         if (inval_stb) begin
            for (int i = 0; i < NUM_ENT; i++) ents[i].valid <= 1'b0;
         end
         if (load_stb) begin
            ents[ptr_q] <= ent_unpack(tag_q, data_q);
            ptr_q       <= ptr_q + 1'b1;
         end
      end
   end

   assign rb_ent   = ents[fault_va[IDX_W-1:0]];
   assign sel_ent  = ents[sel_idx];
   assign sel_mask = offset_mask(sel_ent.size);

   assign lk_hit   = lk_valid && ctrl_en && any_match;
   assign miss_evt = lk_valid && ctrl_en && !any_match;
   assign lk_pa    = lk_hit ? (({sel_ent.ppn, 12'h000} & ~sel_mask) | (lk_va & sel_mask)) : '0;
   assign lk_attr  = lk_hit ? sel_ent.attr : '0;

endmodule

// File: rtl/xlat_tlb_chk.sv
`timescale 1ns/1ps
module xlat_tlb_chk #(
   parameter int IDX_W = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             rg_wr,
   input logic             rg_rd,
   input logic [31:0]      rg_rdata,
   input logic             lk_valid,
   input logic [31:0]      lk_va,
   input logic             lk_hit,
   input logic [31:0]      lk_pa,
   input logic             ctrl_en,
   input logic             win_sel,
   input logic             load_stb,
   input logic [IDX_W-1:0] ptr_q,
   input logic             miss_flag,
   input logic [31:0]      fault_va
);

   a_r3_offset_passes: assert property (@(posedge clk) disable iff (!rst_n)
      lk_hit |-> lk_pa[11:0] == lk_va[11:0]);

   a_r12_off_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_en |-> !lk_hit);

   a_r2_ptr_steps: assert property (@(posedge clk) disable iff (!rst_n)
      load_stb |=> ptr_q == $past(ptr_q) + 1'b1);

   a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (miss_flag && !(rg_wr && win_sel)) |=> miss_flag);

   a_r8_va_held: assert property (@(posedge clk) disable iff (!rst_n)
      (miss_flag && !(rg_wr && win_sel)) |=> $stable(fault_va));

   a_r8_capture: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_valid && ctrl_en && !lk_hit && !miss_flag && !(rg_wr && win_sel))
      |=> (miss_flag && fault_va == $past(lk_va)));

   a_r9_quiet_read: assert property (@(posedge clk) disable iff (!rst_n)
      !(rg_rd && win_sel) |-> rg_rdata == 32'h0);

endmodule

bind xlat_tlb xlat_tlb_chk #(.IDX_W(IDX_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .rg_wr     (rg_wr),
   .rg_rd     (rg_rd),
   .rg_rdata  (rg_rdata),
   .lk_valid  (lk_valid),
   .lk_va     (lk_va),
   .lk_hit    (lk_hit),
   .lk_pa     (lk_pa),
   .ctrl_en   (ctrl_en),
   .win_sel   (win_sel),
   .load_stb  (load_stb),
   .ptr_q     (ptr_q),
   .miss_flag (miss_flag),
   .fault_va  (fault_va)
);

// File: tb/sim_xlat_tlb.sv
`timescale 1ns/1ps
module sim_xlat_tlb;

   localparam int CLK_PERIOD = 10;
   localparam logic [31:0] BASE = 32'hC000_0000;
   localparam logic [31:0] A_CTRL = BASE + 32'h00;
   localparam logic [31:0] A_OPER = BASE + 32'h04;
   localparam logic [31:0] A_STAT = BASE + 32'h08;
   localparam logic [31:0] A_FADR = BASE + 32'h10;
   localparam logic [31:0] A_TAG  = BASE + 32'h14;
   localparam logic [31:0] A_DATA = BASE + 32'h18;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        base_we = 1'b0;
   logic [31:0] base_in = '0;
   logic        rg_wr = 1'b0;
   logic        rg_rd = 1'b0;
   logic [31:0] rg_addr = '0;
   logic [31:0] rg_wdata = '0;
   logic [31:0] rg_rdata;
   logic        lk_valid = 1'b0;
   logic [31:0] lk_va = '0;
   logic [7:0]  lk_asid = '0;
   logic        lk_hit;
   logic [31:0] lk_pa;
   logic [3:0]  lk_attr;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   xlat_tlb u0 (
      .clk(clk), .rst_n(rst_n), .base_we(base_we), .base_in(base_in),
      .rg_wr(rg_wr), .rg_rd(rg_rd), .rg_addr(rg_addr), .rg_wdata(rg_wdata),
      .rg_rdata(rg_rdata), .lk_valid(lk_valid), .lk_va(lk_va), .lk_asid(lk_asid),
      .lk_hit(lk_hit), .lk_pa(lk_pa), .lk_attr(lk_attr)
   );

   function automatic logic [31:0] mk_tag(logic [19:0] vpn, logic [7:0] id, logic sh, logic [1:0] sz);
      return {vpn, id, sh, sz, 1'b1};
   endfunction

   function automatic logic [31:0] mk_data(logic [19:0] ppn, logic [3:0] at);
      return {ppn, 8'h00, at};
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic set_base(logic [31:0] v);
      @(negedge clk); base_we = 1'b1; base_in = v;
      @(negedge clk); base_we = 1'b0;
   endtask

   task automatic wr(logic [31:0] a, logic [31:0] d);
      @(negedge clk); rg_wr = 1'b1; rg_addr = a; rg_wdata = d;
      @(negedge clk); rg_wr = 1'b0;
   endtask

   task automatic rd(logic [31:0] a, output logic [31:0] d);
      @(negedge clk); rg_rd = 1'b1; rg_addr = a;
      #1 d = rg_rdata;
      rg_rd = 1'b0;
   endtask

   task automatic look(logic [31:0] va, logic [7:0] id,
                       output logic hit, output logic [31:0] pa, output logic [3:0] at);
      @(negedge clk); lk_valid = 1'b1; lk_va = va; lk_asid = id;
      #1 hit = lk_hit; pa = lk_pa; at = lk_attr;
      @(negedge clk); lk_valid = 1'b0;
   endtask

   task automatic load(logic [31:0] t, logic [31:0] d);
      wr(A_TAG, t);
      wr(A_DATA, d);
      wr(A_OPER, 32'h1);
   endtask

   task automatic t_reset_and_window;
      logic [31:0] d;
      logic h; logic [31:0] pa; logic [3:0] at;
      look(32'h1234_5678, 8'h00, h, pa, at);
      check("R1 no hit after reset", 32'(h), 32'h0);
      wr(A_CTRL, 32'h1);                       // window not yet valid
      set_base(BASE | 32'h1);
      rd(A_CTRL, d); check("R9 write ignored while base invalid", d, 32'h0);
      rd(A_OPER, d); check("R1 pointer zero", d, 32'h0);
      rd(A_STAT, d); check("R1 status zero", d, 32'h0);
      rd(A_FADR, d); check("R1 fault address zero", d, 32'h0);
      rd(A_TAG, d);  check("R1 tag zero", d, 32'h0);
      rd(A_DATA, d); check("R1 data zero", d, 32'h0);
      wr(A_FADR + 32'h2, 32'hDEAD_BEEF);       // misaligned
      wr(A_FADR + 32'h0001_0000, 32'hFEED_0001); // outside window
      rd(A_FADR, d); check("R9 misaligned/outside writes ignored", d, 32'h0);
      wr(A_CTRL, 32'h1);
      rd(A_CTRL, d); check("R9 aligned write accepted", d, 32'h1);
   endtask

   task automatic t_page_4k;
      logic h; logic [31:0] pa; logic [3:0] at;
      load(mk_tag(20'h12345, 8'h05, 1'b0, 2'b00), mk_data(20'hABCDE, 4'h3));
      look(32'h1234_5678, 8'h05, h, pa, at);
      check("R3/R7 4K hit", 32'(h), 32'h1);
      check("R3/R7 4K pa", pa, 32'hABCD_E678);
      check("R3 4K attr", 32'(at), 32'h3);
      look(32'h1234_6678, 8'h05, h, pa, at);
      check("R3 4K neighbour page misses", 32'(h), 32'h0);
   endtask

   task automatic t_page_sizes;
      logic h; logic [31:0] pa; logic [3:0] at;
      load(mk_tag(20'h20000, 8'h05, 1'b0, 2'b01), mk_data(20'h40002, 4'h5));
      load(mk_tag(20'h30000, 8'h05, 1'b0, 2'b10), mk_data(20'h50000, 4'h6));
      load(mk_tag(20'h71000, 8'h05, 1'b0, 2'b11), mk_data(20'h0A000, 4'h7));
      look(32'h2000_1ABC, 8'h05, h, pa, at);
      check("R4 8K pa", pa, 32'h4000_3ABC);
      check("R4 8K attr", 32'(at), 32'h5);
      look(32'h300A_BCDE, 8'h05, h, pa, at);
      check("R4 1M pa", pa, 32'h500A_BCDE);
      look(32'h7123_4567, 8'h05, h, pa, at);
      check("R4 16M pa", pa, 32'h0A23_4567);
      look(32'h7223_4567, 8'h05, h, pa, at);
      check("R4 16M outside misses", 32'(h), 32'h0);
   endtask

   task automatic t_asid;
      logic h; logic [31:0] pa; logic [3:0] at;
      load(mk_tag(20'h55555, 8'h07, 1'b0, 2'b00), mk_data(20'h00111, 4'h1));
      load(mk_tag(20'h66666, 8'h01, 1'b1, 2'b00), mk_data(20'h00222, 4'h2));
      look(32'h5555_5010, 8'h08, h, pa, at);
      check("R5 wrong id misses", 32'(h), 32'h0);
      look(32'h5555_5010, 8'h07, h, pa, at);
      check("R5 matching id hits", pa, 32'h0011_1010);
      look(32'h6666_6020, 8'h99, h, pa, at);
      check("R5 shared ignores id", pa, 32'h0022_2020);
   endtask

   task automatic t_priority;
      logic h; logic [31:0] pa; logic [3:0] at;
      logic [31:0] d;
      load(mk_tag(20'h12345, 8'h05, 1'b0, 2'b00), mk_data(20'h11111, 4'h9));
      look(32'h1234_5678, 8'h05, h, pa, at);
      check("R6 lowest index wins", pa, 32'hABCD_E678);
      rd(A_OPER, d); check("R2 pointer after seven loads", d, 32'h7);
   endtask

   task automatic t_miss;
      logic h; logic [31:0] pa; logic [3:0] at;
      logic [31:0] d;
      wr(A_STAT, 32'h1);
      rd(A_STAT, d); check("R8 flag cleared", d, 32'h0);
      look(32'h0BAD_0123, 8'h05, h, pa, at);
      rd(A_STAT, d); check("R8 miss flag set", d, 32'h1);
      rd(A_FADR, d); check("R8 fault va captured", d, 32'h0BAD_0123);
      look(32'h0CCC_0000, 8'h05, h, pa, at);
      rd(A_FADR, d); check("R8 later miss keeps first va", d, 32'h0BAD_0123);
      wr(A_STAT, 32'h1);
      rd(A_STAT, d); check("R8 flag cleared by write", d, 32'h0);
   endtask

   task automatic t_readback;
      logic [31:0] d;
      wr(A_FADR, 32'h2);
      wr(A_OPER, 32'h4);
      rd(A_TAG, d);  check("R10 tag of entry 2", d, mk_tag(20'h30000, 8'h05, 1'b0, 2'b10));
      rd(A_DATA, d); check("R10 data of entry 2", d, mk_data(20'h50000, 4'h6));
   endtask

   task automatic t_wrap;
      logic h; logic [31:0] pa; logic [3:0] at;
      logic [31:0] d;
      for (int k = 0; k < 25; k++)
         load(mk_tag(20'h90000 + 20'(k), 8'h00, 1'b0, 2'b00), mk_data(20'h00001, 4'h0));
      rd(A_OPER, d); check("R2 pointer wraps to 0", d, 32'h0);
      load(mk_tag(20'hE0000, 8'h00, 1'b0, 2'b00), mk_data(20'h00002, 4'h0));
      rd(A_OPER, d); check("R2 pointer after wrap load", d, 32'h1);
      look(32'h1234_5678, 8'h05, h, pa, at);
      check("R2/R6 entry 0 replaced, entry 6 serves", pa, 32'h1111_1678);
   endtask

   task automatic t_disable;
      logic h; logic [31:0] pa; logic [3:0] at;
      logic [31:0] d;
      wr(A_STAT, 32'h1);
      wr(A_CTRL, 32'h0);
      look(32'h1234_5678, 8'h05, h, pa, at);
      check("R12 disabled no hit", 32'(h), 32'h0);
      look(32'h0EEE_0000, 8'h05, h, pa, at);
      rd(A_STAT, d); check("R12 disabled records no miss", d, 32'h0);
      wr(A_CTRL, 32'h1);
   endtask

   task automatic t_invalidate;
      logic h; logic [31:0] pa; logic [3:0] at;
      look(32'h300A_BCDE, 8'h05, h, pa, at);
      check("R11 hit before invalidate", 32'(h), 32'h1);
      wr(A_OPER, 32'h2);
      look(32'h300A_BCDE, 8'h05, h, pa, at);
      check("R11 miss after invalidate", 32'(h), 32'h0);
   endtask

   task automatic summary;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      t_reset_and_window();
      t_page_4k();
      t_page_sizes();
      t_asid();
      t_priority();
      t_miss();
      t_readback();
      t_wrap();
      t_disable();
      t_invalidate();
      done = 1'b1;
      summary();
      $finish;
   end

endmodule